// File: doc/BRIEF.md
# Dual Banked Data Pointer Unit

This block holds two 16-bit data pointers for an 8051-style core and steers every pointer access to one of them. Bit 0 of an auxiliary special-function register picks the active bank. The core reaches the active pointer through two byte-wide SFR addresses and through three single-cycle commands: increment, immediate load, and an accumulator-indexed address. The inactive pointer keeps its value until it is selected again.

The bank choice is a two-state machine. In state `BANK0`, pointer 0 is active. In state `BANK1`, pointer 1 is active. The transition `BANK0 -> BANK1` happens on a write to the auxiliary register with data bit 0 set. The transition `BANK1 -> BANK0` happens on such a write with bit 0 clear. Every other cycle holds the current state. Reset enters `BANK0`.

The core uses `xmem_addr` as the external-data-memory address for both reads and writes. It uses `code_addr` for indexed code fetches and indirect jumps.

Top module: `xptr_unit`

## Requirements
- R1: After reset, both pointers read 0000h, the auxiliary register reads 00h, and pointer 0 is active.
- R2: A write to SFR address 8Eh takes the bank from data bit 0 in the next cycle. A value of 0 selects pointer 0 and a value of 1 selects pointer 1.
- R3: SFR address 82h reads and writes the low byte of the active pointer, and 83h reads and writes its high byte. The inactive pointer is never changed.
- R4: `ptr_inc` adds 1 to the full 16-bit active pointer, with a carry from the low byte into the high byte. FFFFh wraps to 0000h.
- R5: `ptr_load` writes `ptr_imm` into the active pointer in a single cycle.
- R6: `xmem_addr` always equals the active pointer.
- R7: `code_addr` equals the active pointer plus the zero-extended `acc`, modulo 2^16.
- R8: Bits 7..1 of the register at 8Eh are stored and read back unchanged, and they have no effect on which pointer is active.
- R9: When a command and an SFR byte write target the active pointer in the same cycle, the command wins. When load and increment come together, load wins.
- R10: The bank select keeps its value through pointer commands and pointer writes until 8Eh is rewritten.
- R11: A read from any other SFR address returns 00h, and a write to one changes neither pointer nor the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data, combinational |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_load | input | 1 | Load `ptr_imm` into the active pointer |
| ptr_imm | input | 16 | Immediate value for a load |
| acc | input | 8 | Accumulator, used as the index |
| xmem_addr | output | 16 | External data memory address |
| code_addr | output | 16 | Indexed code or jump target |

## Verification
The hardest case to reach is one where the bank changes between a pointer update and the next access to that pointer. The point is to show that the inactive pointer really is untouched. To get there, the stimulus fills pointer 0, switches to bank 1, works on pointer 1 through byte writes and commands, then switches back and reads pointer 0 through the byte addresses. It also writes 8Eh with bit 0 clear and the upper bits set, to show that those bits leave the bank alone. Finally it issues SFR byte writes together with loads and increments in the same cycle.

// File: rtl/xptr_pkg.sv
package xptr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    localparam logic [7:0] SFR_PTR_LO = 8'h82;
    localparam logic [7:0] SFR_PTR_HI = 8'h83;
    localparam logic [7:0] SFR_AUX    = 8'h8E;

    typedef struct packed {
        logic lo;
        logic hi;
        logic aux;
    } sfr_hit_t;
endpackage

// File: rtl/xptr_sel_fsm.sv
module xptr_sel_fsm
    import xptr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_we,
    input  logic [DATA_W-1:0] aux_wdata,
    output bank_e             bank,
    output logic [DATA_W-1:0] aux_rd
);
    bank_e              state_q, state_d;
    logic [DATA_W-1:1]  upper_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK0;
            upper_q <= '0;
        end else begin
            state_q <= state_d;
            if (aux_we) upper_q <= aux_wdata[DATA_W-1:1];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK0: if (aux_we && aux_wdata[0])  state_d = BANK1;
            BANK1: if (aux_we && !aux_wdata[0]) state_d = BANK0;
            default: state_d = BANK0;
        endcase
    end

    // outputs
    always_comb begin
        bank   = state_q;
        aux_rd = {upper_q, (state_q == BANK1)};
    end
endmodule

// File: rtl/xptr_bank.sv
module xptr_bank
    import xptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank,
    input  logic              inc,
    input  logic              load,
    input  logic [PTR_W-1:0]  imm,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  active
);
    localparam int HI_W = PTR_W - BYTE_W;

    logic [NBANKS*PTR_W-1:0] flat;

    for (genvar g = 0; g < NBANKS; g++) begin : g_ptr
        logic [PTR_W-1:0] q;
        logic             mine;
        assign mine = (int'(bank) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (mine) begin
                if (load)       q <= imm;
                else if (inc)   q <= q + PTR_W'(1);
                else begin
                    if (wr_lo) q[BYTE_W-1:0]     <= wdata;
                    if (wr_hi) q[PTR_W-1:BYTE_W] <= wdata[HI_W-1:0];
                end
            end
        end

        assign flat[g*PTR_W +: PTR_W] = q;
    end

    always_comb begin
        active = flat[int'(bank)*PTR_W +: PTR_W];
    end
endmodule

// File: rtl/xptr_unit.sv
module xptr_unit
    import xptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              sfr_we,
    output logic [7:0]        sfr_rdata,
    input  logic              ptr_inc,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_imm,
    input  logic [7:0]        acc,
    output logic [PTR_W-1:0]  xmem_addr,
    output logic [PTR_W-1:0]  code_addr
);
    localparam int ACC_PAD = PTR_W - BYTE_W;

    sfr_hit_t         hit;
    bank_e            bank;
    logic [7:0]       aux_rd;
    logic [PTR_W-1:0] active;

    always_comb begin
        hit.lo  = (sfr_addr == SFR_PTR_LO);
        hit.hi  = (sfr_addr == SFR_PTR_HI);
        hit.aux = (sfr_addr == SFR_AUX);
    end

    xptr_sel_fsm #(.DATA_W(8)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .aux_we    (sfr_we && hit.aux),
        .aux_wdata (sfr_wdata),
        .bank      (bank),
        .aux_rd    (aux_rd)
    );

    xptr_bank #(.PTR_W(PTR_W), .NBANKS(2)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .bank   (bank),
        .inc    (ptr_inc),
        .load   (ptr_load),
        .imm    (ptr_imm),
        .wr_lo  (sfr_we && hit.lo),
        .wr_hi  (sfr_we && hit.hi),
        .wdata  (sfr_wdata),
        .active (active)
    );

    always_comb begin
        xmem_addr = active;
        code_addr = active + {{ACC_PAD{1'b0}}, acc};
        if (hit.lo)       sfr_rdata = active[BYTE_W-1:0];
        else if (hit.hi)  sfr_rdata = active[PTR_W-1:BYTE_W];
        else if (hit.aux) sfr_rdata = aux_rd;
        else              sfr_rdata = '0;
    end
endmodule

// File: rtl/xptr_unit_chk.sv
module xptr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sfr_addr,
    input logic [7:0]  sfr_wdata,
    input logic        sfr_we,
    input logic [7:0]  sfr_rdata,
    input logic        ptr_inc,
    input logic        ptr_load,
    input logic [15:0] ptr_imm,
    input logic [7:0]  acc,
    input logic [15:0] xmem_addr,
    input logic [15:0] code_addr,
    input logic        bank
);
    logic aux_wr, byte_wr;
    assign aux_wr  = sfr_we && (sfr_addr == 8'h8E);
    assign byte_wr = sfr_we && (sfr_addr == 8'h82 || sfr_addr == 8'h83);

    a_r2_sel_follows_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        aux_wr |=> bank == $past(sfr_wdata[0]));

    a_r10_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_wr |=> $stable(bank));

    a_r4_inc_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && !aux_wr) |=> xmem_addr == $past(xmem_addr) + 16'd1);

    a_r5_load_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !aux_wr) |=> xmem_addr == $past(ptr_imm));

    a_r7_index_sum: assert property (@(posedge clk) disable iff (!rst_n)
        code_addr == 16'(xmem_addr + {8'h00, acc}));

    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_inc && !ptr_load && !aux_wr && !byte_wr) |=> $stable(xmem_addr));

    a_r3_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'h82) |-> sfr_rdata == xmem_addr[7:0]);
endmodule

bind xptr_unit xptr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_we    (sfr_we),
    .sfr_rdata (sfr_rdata),
    .ptr_inc   (ptr_inc),
    .ptr_load  (ptr_load),
    .ptr_imm   (ptr_imm),
    .acc       (acc),
    .xmem_addr (xmem_addr),
    .code_addr (code_addr),
    .bank      (bank)
);

// File: tb/xptr_unit_bench.sv
module xptr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
    logic        sfr_we = 1'b0, ptr_inc = 1'b0, ptr_load = 1'b0;
    logic [15:0] ptr_imm = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  sfr_rdata;
    logic [15:0] xmem_addr, code_addr;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic [15:0] ref_ptr [2];
    logic [7:0]  ref_aux;

    always #10 clk = ~clk;

    xptr_unit u_xptr_unit (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
        .ptr_load(ptr_load), .ptr_imm(ptr_imm), .acc(acc),
        .xmem_addr(xmem_addr), .code_addr(code_addr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare outputs against the model, advance the model
    task automatic cyc(input string tag, input logic [7:0] a, input logic [7:0] wd,
                       input logic we, input logic inc, input logic ld,
                       input logic [15:0] imm, input logic [7:0] ac);
        int s;
        logic [7:0] exp_rd;
        @(negedge clk);
        sfr_addr = a; sfr_wdata = wd; sfr_we = we;
        ptr_inc = inc; ptr_load = ld; ptr_imm = imm; acc = ac;
        #5;
        s = int'(ref_aux[0]);
        exp_rd = (a == 8'h82) ? ref_ptr[s][7:0] :
                 (a == 8'h83) ? ref_ptr[s][15:8] :
                 (a == 8'h8E) ? ref_aux : 8'h00;
        chk(tag, "xmem_addr (R6)", xmem_addr, ref_ptr[s]);
        chk(tag, "code_addr (R7)", code_addr, 16'(ref_ptr[s] + {8'h00, ac}));
        chk(tag, "sfr_rdata", {8'h00, sfr_rdata}, {8'h00, exp_rd});
        @(posedge clk);
        if (ld)       ref_ptr[s] = imm;
        else if (inc) ref_ptr[s] = ref_ptr[s] + 16'd1;
        else if (we && a == 8'h82) ref_ptr[s][7:0]  = wd;
        else if (we && a == 8'h83) ref_ptr[s][15:8] = wd;
        if (we && a == 8'h8E) ref_aux = wd;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
    end

    initial begin
        ref_ptr[0] = '0; ref_ptr[1] = '0; ref_aux = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        cyc("R1", 8'h8E, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R1", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R1", 8'h83, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        // R3 byte writes to pointer 0
        cyc("R3", 8'h82, 8'h34, 1, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h83, 8'h12, 1, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h83, 8'h00, 0, 0, 0, 16'h0, 8'h07);
        // R5 load, R4 increment with carry and wrap
        cyc("R5", 8'h00, 8'h00, 0, 0, 1, 16'hABCD, 8'h00);
        cyc("R4", 8'h00, 8'h00, 0, 1, 0, 16'h0, 8'h00);
        cyc("R4", 8'h00, 8'h00, 0, 0, 1, 16'h00FF, 8'h00);
        cyc("R4", 8'h00, 8'h00, 0, 1, 0, 16'h0, 8'h00);
        cyc("R4", 8'h00, 8'h00, 0, 0, 1, 16'hFFFF, 8'h00);
        cyc("R4", 8'h00, 8'h00, 0, 1, 0, 16'h0, 8'h00);
        // R7 indexed sum with wrap
        cyc("R7", 8'h00, 8'h00, 0, 0, 1, 16'hFFF0, 8'hFF);
        cyc("R7", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h80);
        // R2 switch to pointer 1, R3 pointer 0 untouched
        cyc("R2", 8'h8E, 8'h01, 1, 0, 0, 16'h0, 8'h00);
        cyc("R2", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h82, 8'h55, 1, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h83, 8'h66, 1, 0, 0, 16'h0, 8'h00);
        cyc("R10", 8'h00, 8'h00, 0, 1, 0, 16'h0, 8'h11);
        cyc("R10", 8'h00, 8'h00, 0, 1, 0, 16'h0, 8'h00);
        cyc("R2", 8'h8E, 8'h00, 1, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R3", 8'h83, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        // R8 upper aux bits stored, no selection effect
        cyc("R8", 8'h8E, 8'hFE, 1, 0, 0, 16'h0, 8'h00);
        cyc("R8", 8'h8E, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R8", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R8", 8'h8E, 8'hA5, 1, 0, 0, 16'h0, 8'h00);
        cyc("R8", 8'h8E, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        // R9 command beats byte write, load beats inc
        cyc("R9", 8'h82, 8'h99, 1, 1, 0, 16'h0, 8'h00);
        cyc("R9", 8'h83, 8'h77, 1, 0, 1, 16'h1234, 8'h00);
        cyc("R9", 8'h00, 8'h00, 0, 1, 1, 16'h4321, 8'h00);
        cyc("R9", 8'h82, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        // R11 unmapped addresses
        cyc("R11", 8'h80, 8'hEE, 1, 0, 0, 16'h0, 8'h00);
        cyc("R11", 8'h8F, 8'h01, 1, 0, 0, 16'h0, 8'h00);
        cyc("R11", 8'h80, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        cyc("R11", 8'h8E, 8'h00, 0, 0, 0, 16'h0, 8'h00);
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule